// File: doc/BRIEF.md
# Two's-Complement Four-Operation Arithmetic Unit

This block is a combinational arithmetic unit of parameterised width. A 2-bit operation code picks one of four two's-complement operations: negate the first operand, negate the second operand, subtract the second operand from the first, or add the two. The unit returns a result word, the carry out of its top bit and a signed overflow flag. It has no clock and no storage, so the outputs follow the inputs within the same cycle.

The datapath is a ripple chain of identical one-bit adder slices. A decoder turns the operation code into a small set of gating controls. Every slice applies those controls to its own operand bits, which may pass through, be inverted or be forced to zero, before it adds them. The decoder also drives the carry into bit 0. A negation is built as the inverted operand plus one, with the other adder input held at zero.

Top module: `twos_arith_alu`

## Requirements
- R1: With `op_sel` = 2'b00, `result` equals the two's-complement negation of `opnd_a`, modulo 2^W.
- R2: With `op_sel` = 2'b01, `result` equals the two's-complement negation of `opnd_b`, modulo 2^W.
- R3: With `op_sel` = 2'b10, `result` equals `opnd_a` minus `opnd_b`, modulo 2^W.
- R4: With `op_sel` = 2'b11, `result` equals `opnd_a` plus `opnd_b`, modulo 2^W.
- R5: `carry_out` is the carry leaving the top slice. For addition it is 1 exactly when the unsigned sum reaches 2^W. For subtraction it is 1 exactly when `opnd_a` >= `opnd_b` as unsigned values, meaning no borrow. For a negation it is 1 exactly when the negated operand is zero.
- R6: `ovf` is 1 exactly when the true signed result of the selected operation lies outside the range -2^(W-1) .. 2^(W-1)-1.
- R7: Negating the most negative value (only bit W-1 set) returns that same value with `ovf` = 1.
- R8: In a negation, the operand that is not negated has no effect on `result`, `carry_out` or `ovf`.
- R9: The outputs respond to new inputs in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | W | First operand |
| opnd_b | input | W | Second operand |
| op_sel | input | 2 | Operation code: 00 negate A, 01 negate B, 10 A-B, 11 A+B |
| result | output | W | Result word |
| carry_out | output | 1 | Carry out of the most significant slice |
| ovf | output | 1 | Signed overflow |

## Verification
The bench targets four kinds of corner case: negating zero, negating the most negative value, subtracting across the sign boundary, and adding two values of the same sign that wrap. A carry-in injected on the wrong operations would put every negation and every difference off by one. A gating error would make the idle operand leak into a negation. An overflow formed from the wrong carry pair would miss 0x80 minus 1 or raise a flag on 0xFF plus 1. A swapped or missing inversion would turn A-B into B-A, which the asymmetric subtraction vectors reveal.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [1:0] {
        OP_NEG_A = 2'b00,
        OP_NEG_B = 2'b01,
        OP_SUB   = 2'b10,
        OP_ADD   = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic zero_a;
        logic inv_a;
        logic zero_b;
        logic inv_b;
    } opnd_gate_t;

    typedef struct packed {
        opnd_gate_t gate;
        logic       carry_in;
    } alu_ctl_t;

    function automatic alu_ctl_t decode_op(input alu_op_e op);
        alu_ctl_t c;
        c = '0;
        unique case (op)
            OP_NEG_A: begin
                c.gate.inv_a  = 1'b1;
                c.gate.zero_b = 1'b1;
                c.carry_in    = 1'b1;
            end
            OP_NEG_B: begin
                c.gate.zero_a = 1'b1;
                c.gate.inv_b  = 1'b1;
                c.carry_in    = 1'b1;
            end
            OP_SUB: begin
                c.gate.inv_b  = 1'b1;
                c.carry_in    = 1'b1;
            end
            default: begin
                c.carry_in    = 1'b0;
            end
        endcase
        return c;
    endfunction

    function automatic logic gate_bit(input logic d, input logic zero, input logic inv);
        return zero ? 1'b0 : (d ^ inv);
    endfunction

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
    import alu_pkg::*;
(
    input  logic [1:0] op_code,
    output alu_ctl_t   ctl
);
    always_comb begin
        ctl = decode_op(alu_op_e'(op_code));
    end
endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import alu_pkg::*;
(
    input  logic       a_bit,
    input  logic       b_bit,
    input  opnd_gate_t gate,
    input  logic       c_in,
    output logic       s_bit,
    output logic       c_out
);
    logic x;
    logic y;

    always_comb begin
        x     = gate_bit(a_bit, gate.zero_a, gate.inv_a);
        y     = gate_bit(b_bit, gate.zero_b, gate.inv_b);
        s_bit = x ^ y ^ c_in;
        c_out = (x & y) | (c_in & (x ^ y));
    end
endmodule

// File: rtl/alu_ripple_chain.sv
module alu_ripple_chain
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  opnd_gate_t   gate,
    input  logic         c0,
    output logic [W-1:0] sum,
    output logic         c_into_msb,
    output logic         c_from_msb
);
    logic [W:0] carry;

    assign carry[0] = c0;

    for (genvar i = 0; i < W; i++) begin : g_slice
        alu_bit_slice u_slice (
            .a_bit (a[i]),
            .b_bit (b[i]),
            .gate  (gate),
            .c_in  (carry[i]),
            .s_bit (sum[i]),
            .c_out (carry[i+1])
        );
    end

    assign c_into_msb = carry[W-1];
    assign c_from_msb = carry[W];
endmodule

// File: rtl/twos_arith_alu.sv
module twos_arith_alu
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [1:0]   op_sel,
    output logic [W-1:0] result,
    output logic         carry_out,
    output logic         ovf
);
    alu_ctl_t ctl;
    logic     c_msb_in;
    logic     c_msb_out;

    alu_op_decode u_dec (
        .op_code (op_sel),
        .ctl     (ctl)
    );

    alu_ripple_chain #(.W(W)) u_chain (
        .a          (opnd_a),
        .b          (opnd_b),
        .gate       (ctl.gate),
        .c0         (ctl.carry_in),
        .sum        (result),
        .c_into_msb (c_msb_in),
        .c_from_msb (c_msb_out)
    );

    assign carry_out = c_msb_out;
    assign ovf       = c_msb_in ^ c_msb_out;
endmodule

// File: rtl/alu_checks.sv
module alu_checks #(
    parameter int W = 8
) (
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [1:0]   op_sel,
    input logic [W-1:0] result,
    input logic         carry_out,
    input logic         ovf
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam int M = W - 1;

    logic [W:0] wide_sum;
    assign wide_sum = {1'b0, opnd_a} + {1'b0, opnd_b};

    always_comb begin
        if (op_sel == 2'b00) begin
            AST_NEG_A_VALUE: assert (result == W'(-opnd_a)); // R1
            AST_NEG_A_CARRY: assert (carry_out == (opnd_a == '0)); // R5
            AST_NEG_A_OVF: assert (ovf == (opnd_a == MOST_NEG)); // R7
        end
        if (op_sel == 2'b01) begin
            AST_NEG_B_VALUE: assert (result == W'(-opnd_b)); // R2
            AST_NEG_B_CARRY: assert (carry_out == (opnd_b == '0)); // R5
            AST_NEG_B_OVF: assert (ovf == (opnd_b == MOST_NEG)); // R7
        end
        if (op_sel == 2'b10) begin
            AST_SUB_VALUE: assert (result == W'(opnd_a - opnd_b)); // R3
            AST_SUB_CARRY: assert (carry_out == (opnd_a >= opnd_b)); // R5
            AST_SUB_OVF: assert (ovf == ((opnd_a[M] != opnd_b[M]) && (result[M] != opnd_a[M]))); // R6
        end
        if (op_sel == 2'b11) begin
            AST_ADD_VALUE: assert (result == wide_sum[W-1:0]); // R4
            AST_ADD_CARRY: assert (carry_out == wide_sum[W]); // R5
            AST_ADD_OVF: assert (ovf == ((opnd_a[M] == opnd_b[M]) && (result[M] != opnd_a[M]))); // R6
        end
    end
endmodule

bind twos_arith_alu alu_checks #(.W(W)) u_chk (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .op_sel    (op_sel),
    .result    (result),
    .carry_out (carry_out),
    .ovf       (ovf)
);

// File: tb/sim_twos_arith_alu.sv
module sim_twos_arith_alu;
    localparam int W = 8;
    localparam int NV = 15;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [W-1:0] a, b, y;
    logic [1:0]   sel;
    logic         c, v;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    twos_arith_alu #(.W(W)) u0 (
        .opnd_a    (a),
        .opnd_b    (b),
        .op_sel    (sel),
        .result    (y),
        .carry_out (c),
        .ovf       (v)
    );

    // {sel, a, b, result, carry, ovf}
    localparam logic [27:0] VEC [NV] = '{
        {2'b00, 8'h05, 8'h33, 8'hFB, 1'b0, 1'b0}, // R1
        {2'b00, 8'h00, 8'h12, 8'h00, 1'b1, 1'b0}, // R1 R5 zero
        {2'b00, 8'h80, 8'h00, 8'h80, 1'b0, 1'b1}, // R7
        {2'b01, 8'h44, 8'h01, 8'hFF, 1'b0, 1'b0}, // R2
        {2'b01, 8'h77, 8'h7F, 8'h81, 1'b0, 1'b0}, // R2
        {2'b01, 8'h00, 8'h80, 8'h80, 1'b0, 1'b1}, // R7
        {2'b10, 8'h10, 8'h03, 8'h0D, 1'b1, 1'b0}, // R3
        {2'b10, 8'h03, 8'h10, 8'hF3, 1'b0, 1'b0}, // R3 borrow
        {2'b10, 8'h80, 8'h01, 8'h7F, 1'b1, 1'b1}, // R6
        {2'b10, 8'h7F, 8'hFF, 8'h80, 1'b0, 1'b1}, // R6
        {2'b10, 8'h05, 8'h05, 8'h00, 1'b1, 1'b0}, // R3 equal
        {2'b11, 8'h7F, 8'h01, 8'h80, 1'b0, 1'b1}, // R6
        {2'b11, 8'hFF, 8'h01, 8'h00, 1'b1, 1'b0}, // R4 R5
        {2'b11, 8'h80, 8'h80, 8'h00, 1'b1, 1'b1}, // R6
        {2'b11, 8'h12, 8'h34, 8'h46, 1'b0, 1'b0}  // R4
    };

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s sel=%b a=%h b=%h actual=%h expected=%h", req, sel, a, b, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] s, input logic [W-1:0] xa, input logic [W-1:0] xb);
        @(negedge clk);
        sel = s; a = xa; b = xb;
        #1;
    endtask

    task automatic ref_check(input logic [1:0] s, input logic [W-1:0] xa, input logic [W-1:0] xb);
        int sa, sb, sr;
        logic [W-1:0] ey;
        logic ec;
        sa = $signed(xa);
        sb = $signed(xb);
        case (s)
            2'b00:   begin sr = -sa;     ec = (xa == 0); end
            2'b01:   begin sr = -sb;     ec = (xb == 0); end
            2'b10:   begin sr = sa - sb; ec = (xa >= xb); end
            default: begin sr = sa + sb; ec = ((int'(xa) + int'(xb)) > 255); end
        endcase
        ey = sr[W-1:0];
        apply(s, xa, xb);
        check(s == 2'b00 ? "R1" : s == 2'b01 ? "R2" : s == 2'b10 ? "R3" : "R4", y, ey);
        check("R5", {7'b0, c}, {7'b0, ec});
        check("R6", {7'b0, v}, {7'b0, (sr > 127 || sr < -128)});
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        sel = 2'b00; a = '0; b = '0;
        @(negedge clk);
        #1;
        // initial state: negate zero gives zero with carry, no overflow (R1 R5)
        check("R1", y, 8'h00);
        check("R5", {7'b0, c}, 8'h01);
        check("R6", {7'b0, v}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][27:26], VEC[i][25:18], VEC[i][17:10]);
            check("R1-R4 table", y, VEC[i][9:2]);
            check("R5", {7'b0, c}, {7'b0, VEC[i][1]});
            check("R6", {7'b0, v}, {7'b0, VEC[i][0]});
        end

        // R8: idle operand changes leave negations unchanged
        for (int k = 0; k < 8; k++) begin
            apply(2'b00, 8'h3C, 8'(k * 37));
            check("R8", y, 8'hC4);
            check("R8", {6'b0, c, v}, 8'h00);
            apply(2'b01, 8'(k * 41), 8'h01);
            check("R8", y, 8'hFF);
            check("R8", {6'b0, c, v}, 8'h00);
        end

        // R9: output follows input change in the same cycle
        apply(2'b11, 8'h01, 8'h02);
        a = 8'h10;
        #1;
        check("R9", y, 8'h12);

        // R7 explicit: most negative negated
        apply(2'b00, 8'h80, 8'h5A);
        check("R7", y, 8'h80);
        check("R7", {7'b0, v}, 8'h01);

        // reference sweep over all operations
        for (int s = 0; s < 4; s++)
            for (int ia = 0; ia < 256; ia += 17)
                for (int ib = 0; ib < 256; ib += 23)
                    ref_check(2'(s), 8'(ia), 8'(ib));

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule